// File: doc/BRIEF.md
# Interprocessor Interrupt Send and Accept Unit

This block sits beside one processor core and handles interprocessor interrupt messages in both directions. On the send side, software writes a 64-bit command word as two 32-bit halves; writing the low half launches a message carrying a vector, a delivery mode, a destination mode, an 8-bit destination and a 2-bit target shorthand. The message stays on the outgoing port, and the block reports itself busy, until the message fabric takes it with a ready/valid handshake.

On the receive side, every incoming message is checked against this core's identity. The checks are the shorthand, the core's physical ID and its logical group mask. An accepted vectored message sets a bit in a 256-entry pending array. The block presents to the core the highest pending vector whose priority class, vector bits 7:4, is above the class held in bits 7:4 of the task priority input. Vectors below 16 are reserved. Using one, on either side, is recorded in a sticky two-bit error status. Messages in non-maskable mode skip the pending array and the priority gate and raise a separate one-cycle output.

Top module: `ipi_unit`

## Requirements
- R1: A write of the low command half (vector in bits 7:0, delivery mode in bits 10:8, logical destination mode in bit 11, shorthand in bits 19:18) launches a message one cycle later. Its destination is bits 31:24 of the most recent high-half write.
- R2: A launched message holds its fields and keeps `cmd_busy`/`tx_valid` at 1 until a cycle with `tx_ready` at 1. A low-half write while busy is ignored.
- R3: A low-half write in fixed (000) or lowest-priority (001) mode with a vector below 16 launches nothing and sets `err_status` bit 0.
- R4: Receive shorthand 01 accepts only when `rx_src` equals `local_id`, 10 accepts always, 11 accepts only when `rx_src` differs from `local_id`, and 00 uses destination matching.
- R5: With shorthand 00 and physical mode (`rx_logical`=0), a message is accepted only when `rx_dest` equals `local_id`.
- R6: With shorthand 00 and logical mode, a message is accepted when `rx_dest` AND `logical_mask` is nonzero, or when `rx_dest` is 0xFF.
- R7: An accepted fixed or lowest-priority message with vector 16 or above sets its `pending` bit one cycle later. Rejected messages and other modes except non-maskable leave `pending` unchanged.
- R8: An accepted fixed or lowest-priority message with a vector below 16 sets `err_status` bit 1 and leaves `pending` unchanged.
- R9: `int_req`/`int_vec` show the highest pending vector whose bits 7:4 exceed `task_prio` bits 7:4. Pending vectors at or below that class stay pending and appear once the threshold drops.
- R10: An accepted message in non-maskable mode (100) pulses `nmi_out` for one cycle, whatever the task priority, and leaves `pending` unchanged.
- R11: `int_ack` while `int_req` is 1 clears the pending bit of `int_vec` at the next edge.
- R12: `err_status` bits are sticky until a cycle with `err_clr` at 1 clears them.
- R13: After reset, `pending`, `err_status`, `tx_valid`, `cmd_busy`, `nmi_out` and `int_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | 8 | Physical identity of this core |
| logical_mask | input | 8 | Logical group membership mask |
| task_prio | input | 8 | Task priority; bits 7:4 are the threshold class |
| cmd_wr_lo | input | 1 | Write low command half and launch |
| cmd_wr_hi | input | 1 | Write high command half (destination) |
| cmd_wdata | input | 32 | Command write data |
| cmd_busy | output | 1 | Delivery status: message not yet handed off |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Fabric takes the outgoing message |
| tx_vector | output | 8 | Outgoing vector |
| tx_mode | output | 3 | Outgoing delivery mode |
| tx_logical | output | 1 | Outgoing destination mode, 1 = logical |
| tx_dest | output | 8 | Outgoing destination |
| tx_shorthand | output | 2 | Outgoing target shorthand |
| rx_valid | input | 1 | Incoming message valid |
| rx_src | input | 8 | Sender identity of incoming message |
| rx_vector | input | 8 | Incoming vector |
| rx_mode | input | 3 | Incoming delivery mode |
| rx_logical | input | 1 | Incoming destination mode |
| rx_dest | input | 8 | Incoming destination |
| rx_shorthand | input | 2 | Incoming target shorthand |
| pending | output | 256 | Pending request array, one bit per vector |
| int_req | output | 1 | An eligible vector is presented |
| int_vec | output | 8 | Presented vector |
| int_ack | input | 1 | Core takes the presented vector |
| nmi_out | output | 1 | Non-maskable interrupt pulse |
| err_status | output | 2 | Bit 0 send illegal vector, bit 1 receive illegal vector |
| err_clr | input | 1 | Clear the error status |

## Verification
Every registered result appears one edge after its stimulus. These are launch after a low-half write, hand-off after `tx_ready`, setting of a pending bit, the error bits, the non-maskable pulse and clearing on acknowledge. The bench drives on the falling edge, lets one rising edge pass, and compares at the next falling edge. `int_req` and `int_vec` follow the pending array and the task priority with no register. They are compared at the same falling edge as the pending array, or one falling edge after a change of the threshold. The non-maskable pulse is checked both in its cycle and one cycle later, when it must be gone.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   typedef enum logic [2:0] {
      DM_FIXED  = 3'b000,
      DM_LOWEST = 3'b001,
      DM_M2     = 3'b010,
      DM_M3     = 3'b011,
      DM_NMI    = 3'b100,
      DM_INIT   = 3'b101,
      DM_START  = 3'b110,
      DM_EXTERN = 3'b111
   } dmode_e;

   typedef enum logic [1:0] {
      SH_NONE   = 2'b00,
      SH_SELF   = 2'b01,
      SH_ALL    = 2'b10,
      SH_OTHERS = 2'b11
   } shorthand_e;

   // command low-half field positions (software visible, so fixed)
   localparam int CMD_MODE_LSB = 8;
   localparam int CMD_LOG_BIT  = 11;
   localparam int CMD_SH_LSB   = 18;

   function automatic logic is_vectored(logic [2:0] m);
      return (dmode_e'(m) == DM_FIXED) || (dmode_e'(m) == DM_LOWEST);
   endfunction

endpackage

// File: rtl/ipi_sender.sv
module ipi_sender
   import ipi_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int ID_W      = 8,
   parameter int RSVD_VECS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [31:0]      wdata,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic [VEC_W-1:0] tx_vector,
   output logic [2:0]       tx_mode,
   output logic             tx_logical,
   output logic [ID_W-1:0]  tx_dest,
   output logic [1:0]       tx_sh,
   output logic             reject
);
   logic [ID_W-1:0]  dest_q;
   logic [VEC_W-1:0] w_vec;
   logic [2:0]       w_mode;
   logic             fire;

   assign w_vec  = wdata[VEC_W-1:0];
   assign w_mode = wdata[CMD_MODE_LSB +: 3];
   assign fire   = wr_lo && !tx_valid;
   assign reject = fire && is_vectored(w_mode) && (32'(w_vec) < RSVD_VECS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_q <= '0;
      end else if (wr_hi) begin
         dest_q <= wdata[31 -: ID_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid   <= 1'b0;
         tx_vector  <= '0;
         tx_mode    <= '0;
         tx_logical <= 1'b0;
         tx_dest    <= '0;
         tx_sh      <= '0;
      end else begin
         if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
         end
         if (fire && !reject) begin
            tx_valid   <= 1'b1;
            tx_vector  <= w_vec;
            tx_mode    <= w_mode;
            tx_logical <= wdata[CMD_LOG_BIT];
            tx_sh      <= wdata[CMD_SH_LSB +: 2];
            tx_dest    <= dest_q;
         end
      end
   end
endmodule

// File: rtl/ipi_accept.sv
module ipi_accept
   import ipi_pkg::*;
#(
   parameter int ID_W          = 8,
   parameter bit LOGICAL_BCAST = 1'b1
) (
   input  logic [ID_W-1:0] local_id,
   input  logic [ID_W-1:0] lmask,
   input  logic [ID_W-1:0] src,
   input  logic            logical,
   input  logic [ID_W-1:0] dest,
   input  logic [1:0]      sh,
   output logic            hit
);
   logic dest_hit;
   logic group_hit;

   generate
      if (LOGICAL_BCAST) begin : g_bcast
         assign group_hit = ((dest & lmask) != '0) || (dest == '1);
      end else begin : g_nobcast
         assign group_hit = (dest & lmask) != '0;
      end
   endgenerate

   assign dest_hit = logical ? group_hit : (dest == local_id);

   always_comb begin
      case (shorthand_e'(sh))
         SH_SELF:   hit = (src == local_id);
         SH_ALL:    hit = 1'b1;
         SH_OTHERS: hit = (src != local_id);
         default:   hit = dest_hit;
      endcase
   end
endmodule

// File: rtl/ipi_pending.sv
module ipi_pending #(
   parameter int VEC_W   = 8,
   parameter int CLASS_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [VEC_W-1:0]    set_vec,
   input  logic                ack,
   input  logic [CLASS_W-1:0]  thr_class,
   output logic [(1<<VEC_W)-1:0] pend,
   output logic                req,
   output logic [VEC_W-1:0]    vec
);
   localparam int NV  = 1 << VEC_W;
   localparam int SHF = VEC_W - CLASS_W;

   logic [NV-1:0] elig;

   genvar gi;
   generate
      for (gi = 0; gi < NV; gi++) begin : g_elig
         localparam logic [CLASS_W-1:0] CLS = CLASS_W'(gi >> SHF);
         assign elig[gi] = pend[gi] && (CLS > thr_class);
      end
   endgenerate

   always_comb begin
      req = 1'b0;
      vec = '0;
      for (int i = 0; i < NV; i++) begin
         if (elig[i]) begin
            req = 1'b1;
            vec = VEC_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
      end else begin
         if (ack && req) begin
            pend[vec] <= 1'b0;
         end
         if (set_en) begin
            pend[set_vec] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
   import ipi_pkg::*;
#(
   parameter int VEC_W         = 8,
   parameter int ID_W          = 8,
   parameter int CLASS_W       = 4,
   parameter int RSVD_VECS     = 16,
   parameter bit LOGICAL_BCAST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ID_W-1:0]       local_id,
   input  logic [ID_W-1:0]       logical_mask,
   input  logic [VEC_W-1:0]      task_prio,
   input  logic                  cmd_wr_lo,
   input  logic                  cmd_wr_hi,
   input  logic [31:0]           cmd_wdata,
   output logic                  cmd_busy,
   output logic                  tx_valid,
   input  logic                  tx_ready,
   output logic [VEC_W-1:0]      tx_vector,
   output logic [2:0]            tx_mode,
   output logic                  tx_logical,
   output logic [ID_W-1:0]       tx_dest,
   output logic [1:0]            tx_shorthand,
   input  logic                  rx_valid,
   input  logic [ID_W-1:0]       rx_src,
   input  logic [VEC_W-1:0]      rx_vector,
   input  logic [2:0]            rx_mode,
   input  logic                  rx_logical,
   input  logic [ID_W-1:0]       rx_dest,
   input  logic [1:0]            rx_shorthand,
   output logic [(1<<VEC_W)-1:0] pending,
   output logic                  int_req,
   output logic [VEC_W-1:0]      int_vec,
   input  logic                  int_ack,
   output logic                  nmi_out,
   output logic [1:0]            err_status,
   input  logic                  err_clr
);
   generate
      if (VEC_W > 8 || VEC_W < CLASS_W) begin : g_bad_vec
         $error("VEC_W must be at most 8 and at least CLASS_W");
      end
      if (ID_W > 8 || ID_W < 1) begin : g_bad_id
         $error("ID_W must be 1..8");
      end
      if (RSVD_VECS > (1 << VEC_W)) begin : g_bad_rsvd
         $error("RSVD_VECS exceeds vector space");
      end
   endgenerate

   logic send_rej;
   logic rx_hit;
   logic rx_vectored;
   logic rx_illegal;
   logic rx_set;

   ipi_sender #(.VEC_W(VEC_W), .ID_W(ID_W), .RSVD_VECS(RSVD_VECS)) u_send (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (cmd_wr_lo),
      .wr_hi      (cmd_wr_hi),
      .wdata      (cmd_wdata),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_vector  (tx_vector),
      .tx_mode    (tx_mode),
      .tx_logical (tx_logical),
      .tx_dest    (tx_dest),
      .tx_sh      (tx_shorthand),
      .reject     (send_rej)
   );

   assign cmd_busy = tx_valid;

   ipi_accept #(.ID_W(ID_W), .LOGICAL_BCAST(LOGICAL_BCAST)) u_acc (
      .local_id (local_id),
      .lmask    (logical_mask),
      .src      (rx_src),
      .logical  (rx_logical),
      .dest     (rx_dest),
      .sh       (rx_shorthand),
      .hit      (rx_hit)
   );

   assign rx_vectored = rx_valid && rx_hit && is_vectored(rx_mode);
   assign rx_illegal  = rx_vectored && (32'(rx_vector) < RSVD_VECS);
   assign rx_set      = rx_vectored && !rx_illegal;

   ipi_pending #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (rx_set),
      .set_vec   (rx_vector),
      .ack       (int_ack),
      .thr_class (task_prio[VEC_W-1 -: CLASS_W]),
      .pend      (pending),
      .req       (int_req),
      .vec       (int_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_out    <= 1'b0;
         err_status <= '0;
      end else begin
         nmi_out    <= rx_valid && rx_hit && (dmode_e'(rx_mode) == DM_NMI);
         err_status <= (err_clr ? 2'b00 : err_status) | {rx_illegal, send_rej};
      end
   end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
   parameter int VEC_W   = 8,
   parameter int CLASS_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [VEC_W-1:0]      task_prio,
   input logic                  cmd_wr_lo,
   input logic                  tx_valid,
   input logic                  tx_ready,
   input logic [VEC_W-1:0]      tx_vector,
   input logic [2:0]            tx_mode,
   input logic [7:0]            tx_dest,
   input logic                  rx_valid,
   input logic [2:0]            rx_mode,
   input logic [(1<<VEC_W)-1:0] pending,
   input logic                  int_req,
   input logic [VEC_W-1:0]      int_vec,
   input logic                  int_ack,
   input logic                  nmi_out,
   input logic [1:0]            err_status,
   input logic                  err_clr
);
   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_vector) && $stable(tx_dest)));

   // R3
   tx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> !((tx_mode == 3'b000 || tx_mode == 3'b001) && tx_vector < 16));

   // R7
   pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> ((pending & ~$past(pending)) == '0));

   // R9
   deliver_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (pending[int_vec] && (int_vec[VEC_W-1 -: CLASS_W] > task_prio[VEC_W-1 -: CLASS_W])));

   // R10
   nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_out |-> ($past(rx_valid) && $past(rx_mode) == 3'b100));

   // R11
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_req && !rx_valid) |=> !pending[$past(int_vec)]);

   // R12
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !rx_valid && !cmd_wr_lo) |=> (err_status == 2'b00));
endmodule

bind ipi_unit ipi_unit_chk #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .task_prio  (task_prio),
   .cmd_wr_lo  (cmd_wr_lo),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_vector  (tx_vector),
   .tx_mode    (tx_mode),
   .tx_dest    (8'(tx_dest)),
   .rx_valid   (rx_valid),
   .rx_mode    (rx_mode),
   .pending    (pending),
   .int_req    (int_req),
   .int_vec    (int_vec),
   .int_ack    (int_ack),
   .nmi_out    (nmi_out),
   .err_status (err_status),
   .err_clr    (err_clr)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   local_id = 8'h05;
   logic [7:0]   logical_mask = 8'h24;
   logic [7:0]   task_prio = 8'h00;
   logic         cmd_wr_lo = 1'b0, cmd_wr_hi = 1'b0;
   logic [31:0]  cmd_wdata = '0;
   logic         cmd_busy, tx_valid;
   logic         tx_ready = 1'b0;
   logic [7:0]   tx_vector, tx_dest;
   logic [2:0]   tx_mode;
   logic         tx_logical;
   logic [1:0]   tx_shorthand;
   logic         rx_valid = 1'b0;
   logic [7:0]   rx_src = '0, rx_vector = '0, rx_dest = '0;
   logic [2:0]   rx_mode = '0;
   logic         rx_logical = 1'b0;
   logic [1:0]   rx_shorthand = '0;
   logic [255:0] pending;
   logic         int_req;
   logic [7:0]   int_vec;
   logic         int_ack = 1'b0;
   logic         nmi_out;
   logic [1:0]   err_status;
   logic         err_clr = 1'b0;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [255:0] m_pend = '0;
   logic [1:0]   m_err = '0;
   logic [7:0]   m_dest = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipi_unit u_dut (
      .clk(clk), .rst_n(rst_n), .local_id(local_id), .logical_mask(logical_mask),
      .task_prio(task_prio), .cmd_wr_lo(cmd_wr_lo), .cmd_wr_hi(cmd_wr_hi),
      .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_vector(tx_vector), .tx_mode(tx_mode),
      .tx_logical(tx_logical), .tx_dest(tx_dest), .tx_shorthand(tx_shorthand),
      .rx_valid(rx_valid), .rx_src(rx_src), .rx_vector(rx_vector), .rx_mode(rx_mode),
      .rx_logical(rx_logical), .rx_dest(rx_dest), .rx_shorthand(rx_shorthand),
      .pending(pending), .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack),
      .nmi_out(nmi_out), .err_status(err_status), .err_clr(err_clr)
   );

   task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // acceptance rule, R4 R5 R6
   function automatic bit f_hit(logic [7:0] src, logic lg, logic [7:0] dst, logic [1:0] sh);
      case (sh)
         2'b01:   return src == local_id;
         2'b10:   return 1'b1;
         2'b11:   return src != local_id;
         default: return lg ? (((dst & logical_mask) != 0) || dst == 8'hFF) : (dst == local_id);
      endcase
   endfunction

   // R9 presented vector: {req, vec}
   function automatic logic [8:0] f_best(logic [255:0] p, logic [7:0] t);
      logic [8:0] r = '0;
      for (int i = 0; i < 256; i++)
         if (p[i] && ((i >> 4) > int'(t[7:4]))) r = {1'b1, 8'(i)};
      return r;
   endfunction

   task automatic check_core();
      logic [8:0] b = f_best(m_pend, task_prio);
      check("R7 pending", pending, m_pend);
      check("R8/R3 err_status", 256'(err_status), 256'(m_err));
      check("R9 int_req/int_vec", 256'({int_req, int_req ? int_vec : 8'h00}), 256'(b));
   endtask

   task automatic rx_msg(string tag, logic [7:0] src, logic [7:0] vec, logic [2:0] md,
                         logic lg, logic [7:0] dst, logic [1:0] sh);
      bit h = f_hit(src, lg, dst, sh);
      bit exp_nmi = h && md == 3'b100;
      rx_src = src; rx_vector = vec; rx_mode = md; rx_logical = lg;
      rx_dest = dst; rx_shorthand = sh; rx_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      rx_valid = 1'b0;
      if (h && (md == 3'b000 || md == 3'b001)) begin
         if (vec < 16) m_err[1] = 1'b1;
         else m_pend[vec] = 1'b1;
      end
      check({tag, " accept/pending"}, pending, m_pend);
      check("R10 nmi_out pulse", 256'(nmi_out), 256'(exp_nmi));
      check_core();
   endtask

   task automatic idle_check();
      @(posedge clk); @(negedge clk);
      check("R10 nmi_out one cycle", 256'(nmi_out), 256'(0));
      check_core();
   endtask

   task automatic do_ack();
      logic [8:0] b = f_best(m_pend, task_prio);
      int_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      int_ack = 1'b0;
      if (b[8]) m_pend[b[7:0]] = 1'b0;
      check("R11 ack clears", pending, m_pend);
      check_core();
   endtask

   task automatic set_tpr(logic [7:0] t);
      task_prio = t;
      @(posedge clk); @(negedge clk);
      check_core();
   endtask

   task automatic write_hi(logic [7:0] d);
      cmd_wdata = {d, 24'h0}; cmd_wr_hi = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_wr_hi = 1'b0;
      m_dest = d;
   endtask

   // returns through checks; R1 R2 R3
   task automatic send(logic [7:0] vec, logic [2:0] md, logic lg, logic [1:0] sh);
      bit was_busy = tx_valid;
      bit illegal = (md == 3'b000 || md == 3'b001) && vec < 16;
      logic [7:0] pv = tx_vector;
      cmd_wdata = {12'h0, sh, 6'h0, lg, md, vec}; cmd_wr_lo = 1'b1;
      @(posedge clk); @(negedge clk);
      cmd_wr_lo = 1'b0;
      if (was_busy) begin
         check("R2 busy write ignored", 256'({tx_valid, tx_vector}), 256'({1'b1, pv}));
      end else if (illegal) begin
         m_err[0] = 1'b1;
         check("R3 illegal send not launched", 256'(tx_valid), 256'(0));
         check("R3 err bit0", 256'(err_status), 256'(m_err));
      end else begin
         check("R1 launch valid/busy", 256'({tx_valid, cmd_busy}), 256'(2'b11));
         check("R1 launch fields", 256'({tx_vector, tx_mode, tx_logical, tx_dest, tx_shorthand}),
               256'({vec, md, lg, m_dest, sh}));
      end
   endtask

   task automatic handoff();
      tx_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_ready = 1'b0;
      check("R2 handed off", 256'({tx_valid, cmd_busy}), 256'(0));
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      check("R13 reset pending", pending, '0);
      check("R13 reset flags", 256'({err_status, tx_valid, cmd_busy, nmi_out, int_req}), 256'(0));

      // R5 physical
      rx_msg("R5 phys hit", 8'h01, 8'h40, 3'b000, 1'b0, 8'h05, 2'b00);
      rx_msg("R5 phys miss", 8'h01, 8'h41, 3'b000, 1'b0, 8'h06, 2'b00);
      // R6 logical
      rx_msg("R6 logical hit", 8'h01, 8'h50, 3'b001, 1'b1, 8'h04, 2'b00);
      rx_msg("R6 logical miss", 8'h01, 8'h51, 3'b000, 1'b1, 8'h40, 2'b00);
      rx_msg("R6 logical bcast", 8'h01, 8'h52, 3'b000, 1'b1, 8'hFF, 2'b00);
      // R4 shorthand
      rx_msg("R4 self hit", 8'h05, 8'h60, 3'b000, 1'b0, 8'h00, 2'b01);
      rx_msg("R4 self miss", 8'h07, 8'h61, 3'b000, 1'b0, 8'h05, 2'b01);
      rx_msg("R4 all", 8'h09, 8'h62, 3'b000, 1'b0, 8'h33, 2'b10);
      rx_msg("R4 others self", 8'h05, 8'h63, 3'b000, 1'b0, 8'h05, 2'b11);
      rx_msg("R4 others hit", 8'h02, 8'h64, 3'b000, 1'b0, 8'h00, 2'b11);
      // R8 illegal vector, accepted and rejected
      rx_msg("R8 illegal miss", 8'h01, 8'h0F, 3'b000, 1'b0, 8'h06, 2'b00);
      rx_msg("R8 illegal hit", 8'h01, 8'h0F, 3'b000, 1'b0, 8'h05, 2'b00);
      // R12 sticky
      idle_check();
      // R7 other modes ignored
      rx_msg("R7 init mode ignored", 8'h01, 8'h70, 3'b101, 1'b0, 8'h05, 2'b00);
      // R9 threshold holds, R10 NMI bypasses
      set_tpr(8'h70);
      rx_msg("R10 nmi under high tpr", 8'h01, 8'h20, 3'b100, 1'b0, 8'h05, 2'b00);
      idle_check();
      set_tpr(8'h50);
      do_ack();
      do_ack();
      // R12 clear
      err_clr = 1'b1;
      @(posedge clk); @(negedge clk);
      err_clr = 1'b0;
      m_err = '0;
      check("R12 err cleared", 256'(err_status), 256'(0));

      // send side
      write_hi(8'hA7);
      send(8'h81, 3'b000, 1'b1, 2'b00);
      idle_check();
      check("R2 busy held", 256'({tx_valid, tx_vector}), 256'({1'b1, 8'h81}));
      send(8'h99, 3'b000, 1'b0, 2'b10);
      handoff();
      send(8'h05, 3'b000, 1'b0, 2'b00);
      send(8'h05, 3'b100, 1'b0, 2'b11);
      handoff();

      // random traffic
      for (int k = 0; k < 600; k++) begin
         int sel = $urandom_range(0, 9);
         if (sel < 6) begin
            logic [2:0] md;
            int mm = $urandom_range(0, 7);
            md = (mm < 4) ? 3'b000 : (mm == 4) ? 3'b001 : (mm == 5) ? 3'b100 : 3'b101;
            rx_msg("R7 random rx", ($urandom_range(0,1) != 0) ? local_id : 8'($urandom),
                   8'($urandom), md, 1'($urandom),
                   ($urandom_range(0,2) == 0) ? local_id : 8'($urandom), 2'($urandom));
         end else if (sel == 6) begin
            do_ack();
         end else if (sel == 7) begin
            set_tpr(8'($urandom));
         end else if (sel == 8) begin
            write_hi(8'($urandom));
            send(8'($urandom), 3'($urandom), 1'($urandom), 2'($urandom));
            if (tx_valid) handoff();
         end else begin
            err_clr = 1'b1;
            @(posedge clk); @(negedge clk);
            err_clr = 1'b0;
            m_err = '0;
            check("R12 random clear", 256'(err_status), 256'(0));
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule